// File: doc/BRIEF.md
# Serial to Parallel Printer Bridge

This block accepts asynchronous serial bytes from a host and hands each one to a parallel printer port. The serial frame has one start bit, eight data bits sent least significant bit first, no parity bit and one stop bit. At the default parameters the line runs at 2400 baud.

The receiver samples the line sixteen times per bit. It builds each byte in a shift register. A good byte then moves into a single holding register. A port sequencer takes the byte from that register, drives it onto the eight data lines, and issues an active-low strobe. The sequencer waits for the printer to report not-busy and to return its acknowledge pulse before it sends another byte.

Two handshake lines go back to the host. Clear-to-send drops while the holding register is occupied or the printer is busy, so a well-behaved sender pauses. Data-set-ready is raised once the block is out of reset. A byte that arrives with a bad stop bit is discarded and reported. A byte that arrives while the holding register is still occupied is also discarded, and a sticky overrun flag is set.

Top module: `ser2par_bridge`

## Requirements
- R1: While reset is applied, and in the first cycles after its release, the outputs are as follows: strobe high, data lines 0x00, framing-error low and overrun low. Once released, with busy low, clear-to-send is high.
- R2: A frame is a low start bit, then eight data bits least significant first, then a high stop bit, at CLK_HZ/(BAUD*OVS)*OVS clocks per bit. Each good frame appears as exactly one strobe, and the received byte is on the data lines while the strobe is low. Bytes reach the port in arrival order.
- R3: A low pulse on the serial line that has ended by the middle of the start bit is rejected. It produces no strobe and no framing error.
- R4: A frame whose stop bit samples low raises framing-error for exactly one clock. Its byte never reaches the data lines.
- R5: The data lines hold their new value for at least SETUP_US microseconds of clock cycles before the strobe falls.
- R6: The strobe stays low for exactly STROBE_US microseconds of clock cycles (50 cycles at 50 MHz).
- R7: After the strobe rises, the data lines do not change for at least HOLD_US microseconds of clock cycles.
- R8: No strobe sequence starts while the busy input is high.
- R9: After a strobe, the next strobe falls only once the acknowledge input (active low) has been seen low.
- R10: Clear-to-send is low while the holding register is occupied or busy is high. It falls in the cycle after a byte lands in the holding register.
- R11: A good frame that completes while the holding register is occupied sets overrun. That byte is dropped and the held byte is kept. Overrun stays high until reset.
- R12: Data-set-ready is low during reset and high at all times after reset has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_rxd | input | 1 | Serial data from the host, idle high |
| prn_busy | input | 1 | Printer busy, active high |
| prn_ack_n | input | 1 | Printer acknowledge pulse, active low |
| prn_data | output | DATA_W | Parallel data lines to the printer |
| prn_strobe_n | output | 1 | Data strobe, active low |
| host_cts | output | 1 | Clear-to-send to the host, high means send |
| host_dsr | output | 1 | Data-set-ready to the host |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |
| overrun | output | 1 | Sticky flag, a byte was lost to a full holding register |

## Verification
Several kinds of traffic are used:
- Directed bytes 0xA5, 0x01, 0x80, 0xFF and 0x00 exercise the bit order and both edges of the byte range.
- Random bytes paired with random printer response times separate the case where the printer holds busy from the case where it only delays its acknowledge. This shows that each of the two gates on the strobe works on its own.
- A short false start and a frame with a low stop bit separate a rejected start from a framing error.
- A final run with busy held high sends two frames back to back with clear-to-send ignored. It shows that the first byte is kept, the second is dropped, and overrun stays set.

// File: rtl/ser2par_pkg.sv
package ser2par_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

  typedef enum logic [1:0] {
    PP_IDLE,
    PP_SETUP,
    PP_STROBE,
    PP_HOLD
  } pp_state_e;

endpackage

// File: rtl/s2p_sync.sv
module s2p_sync #(
  parameter int    STAGES  = 2,
  parameter logic  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/s2p_tick_gen.sv
module s2p_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic arst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/s2p_uart_rx.sv
module s2p_uart_rx
  import ser2par_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              tick,
  input  logic              rxd,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] data
);
  localparam int PW = $clog2(OVS);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PW-1:0] MID  = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0] LAST = PW'(OVS - 1);
  localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [PW-1:0]     phase_q, phase_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    done    = 1'b0;
    err     = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (tick && !rxd) begin
          state_d = RX_START;
          phase_d = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (phase_q == MID) begin
            phase_d = '0;
            bit_d   = '0;
            state_d = rxd ? RX_IDLE : RX_DATA;
          end else begin
            phase_d = phase_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (phase_q == LAST) begin
            phase_d = '0;
            sh_d    = {rxd, sh_q[DATA_W-1:1]};
            if (bit_q == BLAST) state_d = RX_STOP;
            else                bit_d   = bit_q + 1'b1;
          end else begin
            phase_d = phase_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (phase_q == LAST) begin
            if (rxd) begin
              done    = 1'b1;
              state_d = RX_IDLE;
            end else begin
              err     = 1'b1;
              state_d = RX_BREAK;
            end
          end else begin
            phase_d = phase_q + 1'b1;
          end
        end
      end
      RX_BREAK: begin
        if (rxd) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= RX_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
    end
  end

  assign data = sh_q;
endmodule

// File: rtl/s2p_hold_reg.sv
module s2p_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              overrun
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ovr_q, ovr_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    ovr_d  = ovr_q;
    if (take) full_d = 1'b0;
    if (load) begin
      if (full_q && !take) begin
        ovr_d = 1'b1;
      end else begin
        full_d = 1'b1;
        data_d = load_data;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
      ovr_q  <= ovr_d;
    end
  end

  assign full    = full_q;
  assign data    = data_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/s2p_lpt_tx.sv
module s2p_lpt_tx
  import ser2par_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 50,
  parameter int STROBE_CYC = 50,
  parameter int HOLD_CYC   = 50
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              have_data,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              busy_s,
  input  logic              ack_s,
  output logic              take,
  output logic [DATA_W-1:0] pd_data,
  output logic              strobe_n
);
  localparam int MAXC = (SETUP_CYC > STROBE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SET_END = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] STB_END = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] HLD_END = CW'(HOLD_CYC - 1);

  pp_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] pd_q, pd_d;
  logic              stb_q, stb_d;
  logic              pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pd_d    = pd_q;
    stb_d   = stb_q;
    pend_d  = pend_q;
    take    = 1'b0;
    if (!ack_s) pend_d = 1'b0;
    case (state_q)
      PP_IDLE: begin
        if (have_data && !busy_s && !pend_q) begin
          take    = 1'b1;
          pd_d    = hold_data;
          cnt_d   = '0;
          state_d = PP_SETUP;
        end
      end
      PP_SETUP: begin
        if (cnt_q == SET_END) begin
          cnt_d   = '0;
          stb_d   = 1'b0;
          pend_d  = 1'b1;
          state_d = PP_STROBE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PP_STROBE: begin
        if (cnt_q == STB_END) begin
          cnt_d   = '0;
          stb_d   = 1'b1;
          state_d = PP_HOLD;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PP_HOLD: begin
        if (cnt_q == HLD_END) begin
          cnt_d   = '0;
          state_d = PP_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = PP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= PP_IDLE;
      cnt_q   <= '0;
      pd_q    <= '0;
      stb_q   <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pd_q    <= pd_d;
      stb_q   <= stb_d;
      pend_q  <= pend_d;
    end
  end

  assign pd_data  = pd_q;
  assign strobe_n = stb_q;
endmodule

// File: rtl/ser2par_bridge.sv
module ser2par_bridge #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BAUD      = 2400,
  parameter int OVS       = 16,
  parameter int DATA_W    = 8,
  parameter int SETUP_US  = 1,
  parameter int STROBE_US = 1,
  parameter int HOLD_US   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_rxd,
  input  logic              prn_busy,
  input  logic              prn_ack_n,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_strobe_n,
  output logic              host_cts,
  output logic              host_dsr,
  output logic              frame_err,
  output logic              overrun
);
  localparam int TICK_DIV   = CLK_HZ / (BAUD * OVS);
  localparam int CYC_PER_US = (CLK_HZ + 999_999) / 1_000_000;
  localparam int SETUP_CYC  = CYC_PER_US * SETUP_US;
  localparam int STROBE_CYC = CYC_PER_US * STROBE_US;
  localparam int HOLD_CYC   = CYC_PER_US * HOLD_US;

  logic [1:0]        rst_pipe_q;
  logic              arst_n;
  logic              rxd_s, busy_s, ack_s, tick;
  logic              rx_done, rx_err;
  logic [DATA_W-1:0] rx_byte, hold_byte;
  logic              hold_full, take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign arst_n = rst_pipe_q[1];

  s2p_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_rxd (
    .clk(clk), .arst_n(arst_n), .d(ser_rxd), .q(rxd_s));
  s2p_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_busy (
    .clk(clk), .arst_n(arst_n), .d(prn_busy), .q(busy_s));
  s2p_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_ack (
    .clk(clk), .arst_n(arst_n), .d(prn_ack_n), .q(ack_s));

  s2p_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .arst_n(arst_n), .tick(tick));

  s2p_uart_rx #(.OVS(OVS), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .arst_n(arst_n), .tick(tick), .rxd(rxd_s),
    .done(rx_done), .err(rx_err), .data(rx_byte));

  s2p_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .arst_n(arst_n), .load(rx_done), .load_data(rx_byte),
    .take(take), .full(hold_full), .data(hold_byte), .overrun(overrun));

  s2p_lpt_tx #(
    .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
    .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_lpt (
    .clk(clk), .arst_n(arst_n), .have_data(hold_full), .hold_data(hold_byte),
    .busy_s(busy_s), .ack_s(ack_s), .take(take),
    .pd_data(prn_data), .strobe_n(prn_strobe_n));

  assign frame_err = rx_err;
  assign host_cts  = arst_n & ~hold_full & ~busy_s;
  assign host_dsr  = arst_n;
endmodule

// File: rtl/ser2par_bridge_chk.sv
module ser2par_bridge_chk #(
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 50,
  parameter int STROBE_CYC = 50,
  parameter int HOLD_CYC   = 50
) (
  input logic              clk,
  input logic              rst_i,
  input logic              strobe_n,
  input logic [DATA_W-1:0] pd_data,
  input logic              ack_s,
  input logic              frame_err,
  input logic              overrun,
  input logic              cts,
  input logic              rx_done
);
  logic              prev_stb, ack_since, stb_seen;
  logic [DATA_W-1:0] prev_data;
  logic [15:0]       chg_cnt, low_cnt, hi_cnt;
  logic              stb_fell, stb_rose, data_chg;

  assign stb_fell = prev_stb & ~strobe_n;
  assign stb_rose = ~prev_stb & strobe_n;
  assign data_chg = (pd_data != prev_data);

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      prev_stb  <= 1'b1;
      prev_data <= '0;
      chg_cnt   <= '0;
      low_cnt   <= '0;
      hi_cnt    <= '0;
      ack_since <= 1'b0;
      stb_seen  <= 1'b0;
    end else begin
      prev_stb  <= strobe_n;
      prev_data <= pd_data;
      chg_cnt   <= data_chg ? '0 : ((&chg_cnt) ? chg_cnt : chg_cnt + 1'b1);
      low_cnt   <= strobe_n ? '0 : low_cnt + 1'b1;
      hi_cnt    <= !strobe_n ? '0 : ((&hi_cnt) ? hi_cnt : hi_cnt + 1'b1);
      if (stb_fell)    ack_since <= 1'b0;
      else if (!ack_s) ack_since <= 1'b1;
      if (stb_fell)    stb_seen  <= 1'b1;
    end
  end

  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_i)
    stb_fell |-> (chg_cnt >= 16'(SETUP_CYC - 1))); // R5
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_i)
    stb_rose |-> (low_cnt == 16'(STROBE_CYC))); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    (data_chg && stb_seen) |-> (hi_cnt >= 16'(HOLD_CYC))); // R7
  AST_ACK_BEFORE_NEXT: assert property (@(posedge clk) disable iff (!rst_i)
    (stb_fell && stb_seen) |-> ack_since); // R9
  AST_FERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_i)
    frame_err |=> !frame_err); // R4
  AST_FERR_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_i)
    frame_err |-> !rx_done); // R4
  AST_CTS_DROP: assert property (@(posedge clk) disable iff (!rst_i)
    rx_done |=> !cts); // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    overrun |=> overrun); // R11
endmodule

bind ser2par_bridge ser2par_bridge_chk #(
  .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
  .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk(clk), .rst_i(arst_n), .strobe_n(prn_strobe_n), .pd_data(prn_data),
  .ack_s(ack_s), .frame_err(frame_err), .overrun(overrun),
  .cts(host_cts), .rx_done(rx_done)
);

// File: tb/ser2par_bridge_test.sv
`timescale 1ns/1ps
module ser2par_bridge_test;
  localparam int CLK_HZ = 50_000_000;
  localparam int BAUD   = 781_250;
  localparam int BIT    = 64;   // 4 clocks per sample tick, 16 ticks per bit
  localparam int PCYC   = 50;   // 1 us at 50 MHz

  logic       clk = 1'b0;
  logic       rst_n, ser_rxd, prn_ack_n, hold_busy, model_busy;
  wire        prn_busy = hold_busy | model_busy;
  logic [7:0] prn_data;
  logic       prn_strobe_n, host_cts, host_dsr, frame_err, overrun;

  always #10 clk = ~clk;

  ser2par_bridge #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) uut (
    .clk(clk), .rst_n(rst_n), .ser_rxd(ser_rxd), .prn_busy(prn_busy),
    .prn_ack_n(prn_ack_n), .prn_data(prn_data), .prn_strobe_n(prn_strobe_n),
    .host_cts(host_cts), .host_dsr(host_dsr), .frame_err(frame_err),
    .overrun(overrun));

  int   checks = 0, failures = 0;
  int   strobes = 0, ferrs = 0;
  int   ack_delay = 40;
  bit   use_busy = 1'b1;
  bit   done_flag = 1'b0;
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] build_frame(input logic [7:0] b, input bit good);
    return {good, b, 1'b0};
  endfunction

  task automatic send_raw(input logic [7:0] b, input bit good);
    logic [9:0] f = build_frame(b, good);
    for (int i = 0; i < 10; i++) begin
      ser_rxd = f[i];
      repeat (BIT) @(posedge clk);
    end
    ser_rxd = 1'b1;
    repeat (good ? BIT : 2 * BIT) @(posedge clk);
  endtask

  task automatic send_good(input logic [7:0] b);
    while (!host_cts) @(posedge clk);
    exp_q.push_back(b);
    send_raw(b, 1'b1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (ack_delay + 300) @(posedge clk);
  endtask

  // printer model
  initial begin
    prn_ack_n  = 1'b1;
    model_busy = 1'b0;
    forever begin
      int d;
      bit wb;
      @(negedge prn_strobe_n);
      d  = ack_delay;
      wb = use_busy;
      if (wb) begin
        repeat (3) @(posedge clk);
        model_busy = 1'b1;
      end
      @(posedge prn_strobe_n);
      repeat (d) @(posedge clk);
      prn_ack_n = 1'b0;
      repeat (6) @(posedge clk);
      prn_ack_n  = 1'b1;
      model_busy = 1'b0;
    end
  end

  // port monitor, sampled on the falling clock edge
  logic       p_stb = 1'b1, p_ferr = 1'b0;
  logic [7:0] p_data = 8'h00;
  int         stable_cnt = 0, low_cnt = 0, hi_cnt = 0, busy_run = 0;
  bit         ack_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if (prn_data != p_data) begin
        if (strobes > 0) check(hi_cnt >= PCYC, "R7", hi_cnt, PCYC);
        stable_cnt = 0;
      end else stable_cnt++;
      busy_run = prn_busy ? busy_run + 1 : 0;
      if (!prn_ack_n) ack_seen = 1'b1;
      if (p_stb && !prn_strobe_n) begin
        logic [7:0] e;
        check(stable_cnt >= PCYC, "R5", stable_cnt, PCYC);
        check(busy_run <= PCYC + 4, "R8", busy_run, PCYC + 4);
        if (strobes > 0) check(ack_seen, "R9", ack_seen, 1);
        e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'hxx;
        check(prn_data === e, "R2", prn_data, e);
        strobes++;
        ack_seen = 1'b0;
      end
      if (!prn_strobe_n) low_cnt++;
      else begin
        if (!p_stb) check(low_cnt == PCYC, "R6", low_cnt, PCYC);
        low_cnt = 0;
      end
      hi_cnt = prn_strobe_n ? hi_cnt + 1 : 0;
      if (frame_err) begin
        ferrs++;
        check(!p_ferr, "R4", 2, 1);
      end
      p_stb  = prn_strobe_n;
      p_data = prn_data;
      p_ferr = frame_err;
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (190_000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int s0, f0;
    void'($urandom(32'h1D5E));
    rst_n = 1'b0; ser_rxd = 1'b1; hold_busy = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(host_dsr == 1'b0, "R12", host_dsr, 0);
    check(prn_strobe_n == 1'b1, "R1", prn_strobe_n, 1);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(host_cts == 1'b1, "R1", host_cts, 1);
    check(host_dsr == 1'b1, "R12", host_dsr, 1);
    check(overrun == 1'b0 && frame_err == 1'b0, "R1", overrun, 0);
    check(prn_data == 8'h00 && prn_strobe_n, "R1", prn_data, 0);

    // R2 directed bit patterns
    send_good(8'hA5); send_good(8'h01); send_good(8'h80);
    send_good(8'hFF); send_good(8'h00);
    drain();

    // R3 short false start
    s0 = strobes; f0 = ferrs;
    ser_rxd = 1'b0;
    repeat (20) @(posedge clk);
    ser_rxd = 1'b1;
    repeat (3 * BIT) @(posedge clk);
    @(negedge clk);
    check(strobes == s0, "R3", strobes, s0);
    check(ferrs == f0, "R3", ferrs, f0);

    // R4 low stop bit
    send_raw(8'h3C, 1'b0);
    repeat (600) @(posedge clk);
    @(negedge clk);
    check(ferrs == f0 + 1, "R4", ferrs, f0 + 1);
    check(strobes == s0, "R4", strobes, s0);
    send_good(8'hC3);
    drain();

    // random bytes with random printer response
    for (int i = 0; i < 16; i++) begin
      ack_delay = 20 + int'($urandom_range(1500));
      use_busy  = $urandom_range(1);
      send_good(8'($urandom));
    end
    ack_delay = 40; use_busy = 1'b1;
    drain();

    // R8 / R10 / R11 with busy held high
    hold_busy = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(host_cts == 1'b0, "R10", host_cts, 0);
    s0 = strobes;
    exp_q.push_back(8'h5A);
    send_raw(8'h5A, 1'b1);
    @(negedge clk);
    check(host_cts == 1'b0 && overrun == 1'b0, "R11", overrun, 0);
    send_raw(8'h96, 1'b1);
    repeat (50) @(posedge clk);
    @(negedge clk);
    check(overrun == 1'b1, "R11", overrun, 1);
    check(strobes == s0, "R8", strobes, s0);
    hold_busy = 1'b0;
    drain();
    @(negedge clk);
    check(strobes == s0 + 1, "R11", strobes, s0 + 1);
    send_good(8'h3E);
    drain();
    @(negedge clk);
    check(overrun == 1'b1, "R11", overrun, 1);
    check(host_dsr == 1'b1, "R12", host_dsr, 1);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    finish_run();
  end
endmodule